// File: doc/BRIEF.md
# Eight-Line Maskable Interrupt Controller

The block merges eight peripheral request lines into one interrupt output for a processor and, when the processor acknowledges, supplies an 8-bit vector number that identifies the requesting line. Each request line passes through a synchroniser. A rising edge on the line latches a pending bit, so a request as short as one clock cycle is kept until it is serviced. A byte-wide mask register blocks individual lines. A fixed priority (lower line number wins) picks one line, and an in-service register stops a line of equal or lower priority from interrupting a handler that is still running.

The processor talks to the block through a small byte-wide port with two addresses. At the mask address it reads and writes the whole mask byte; software changes a single bit by reading the byte, modifying it and writing it back. Any write to the command address is an end-of-interrupt, which retires the highest-priority line that is in service. One request line can be set aside as a cascade input. When a second controller of the same kind drives that line and the line wins arbitration, the block passes the second controller's vector through and forwards the acknowledge to it.

Top module: `irq_ctrl_top`

## Requirements
- R1: After synchronous reset the mask byte reads 0xFF, no line is pending or in service, and `int_o` is low.
- R2: A write with `io_addr`=1 (mask port) replaces all eight mask bits at once, and `io_rdata` with `io_addr`=1 returns the last byte written. Bit n of the mask belongs to line n.
- R3: A 0-to-1 transition on `req_i[n]` sets pending bit n at the third rising clock edge after the input rises, so `int_o` can rise only after that edge. A one-cycle pulse is latched. A level that stays high does not request again.
- R4: A mask bit of 1 keeps its line from asserting `int_o`. A masked line still latches its request, and clearing the mask bit later raises `int_o`.
- R5: Among the unmasked pending lines the lowest-numbered one is selected, and `vec_o` reads VEC_BASE+n (8+n by default, so line 0 gives 8 and line 7 gives 15).
- R6: `ack_i` high at a clock edge while `int_o` is high marks the selected line in service and clears its pending bit.
- R7: While any line is in service, `int_o` is asserted only for unmasked pending lines whose number is strictly lower than that of the lowest-numbered line in service.
- R8: A write with `io_addr`=0 (command port) clears the in-service bit of the lowest-numbered line in service.
- R9: When the cascade line (line 2) is selected, `vec_o` equals `slave_vec_i`, and `slave_ack_o` is high exactly while `ack_i` is high and `int_o` is high.
- R10: A new rising edge on a line in the same cycle as the acknowledge of that line leaves the line pending after the acknowledge.
- R11: `ack_i` while `int_o` is low changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request lines, active high, asynchronous |
| io_wr | input | 1 | Write strobe for the I/O port |
| io_addr | input | 1 | 0 = command port (end-of-interrupt), 1 = mask port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data: mask byte at the mask port, zero at the command port |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the selected line, valid while `int_o` is high |
| slave_vec_i | input | 8 | Vector supplied by a chained controller |
| slave_ack_o | output | 1 | Acknowledge forwarded to the chained controller |

## Verification
Two functions can meet in the same clock edge: a line's pending bit is being cleared by an acknowledge while a fresh rising edge on that same line is trying to set it. The bench starts a one-cycle pulse on a pending line and counts the synchroniser stages so that the edge is detected in exactly the cycle in which `ack_i` is taken. A correct design leaves the line pending but blocked by its own in-service bit. The bench judges this at the ports: `int_o` stays low after the acknowledge, then rises with the same vector once an end-of-interrupt is written.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NLINES = 8;
    localparam int IDXW   = $clog2(NLINES);

    typedef logic [NLINES-1:0] lines_t;
    typedef logic [7:0]        byte_t;

    typedef enum logic {
        PORT_CMD  = 1'b0,
        PORT_MASK = 1'b1
    } port_e;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
    } pick_t;

    // Lowest-numbered set bit; the lowest number has the highest priority.
    function automatic pick_t pick_lowest(lines_t v);
        pick_t p;
        p = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = IDXW'(i);
            end
        end
        return p;
    endfunction

    // One-hot of the lowest-numbered set bit (all zero if none).
    function automatic lines_t lowest_onehot(lines_t v);
        return v & (~v + lines_t'(1));
    endfunction

    // Lines allowed to interrupt beside the current in-service set.
    function automatic lines_t allowed_lines(pick_t top);
        lines_t a;
        for (int i = 0; i < NLINES; i++) begin
            a[i] = !top.valid || (i < int'(top.idx));
        end
        return a;
    endfunction

endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  lines_t req_i,
    output lines_t rise_o
);

    localparam int CHAIN = SYNC_STAGES + 1;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN-2:0], req_i[g]};
            end
        end

        // Synchronised level is chain_q[SYNC_STAGES-1]; the extra flop holds its previous value.
        assign rise_o[g] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end

endmodule

// File: rtl/irqc_io_port.sv
module irqc_io_port
    import irqc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   io_wr,
    input  logic   io_addr,
    input  byte_t  io_wdata,
    output byte_t  io_rdata,
    output lines_t mask_o,
    output logic   eoi_o
);

    port_e  sel;
    lines_t mask_q;

    assign sel = port_e'(io_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (io_wr && sel == PORT_MASK) begin
            mask_q <= lines_t'(io_wdata);
        end
    end

    assign mask_o   = mask_q;
    assign eoi_o    = io_wr && (sel == PORT_CMD);
    assign io_rdata = (sel == PORT_MASK) ? byte_t'(mask_q) : '0;

    assert_mask_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> mask_q == '1);

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr) |=> mask_q == lines_t'($past(io_wdata)));

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !io_wr |=> $stable(mask_q));

endmodule

// File: rtl/irqc_state.sv
module irqc_state
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  lines_t          rise_i,
    input  logic            take_i,
    input  logic [IDXW-1:0] take_idx_i,
    input  logic            eoi_i,
    output lines_t          pend_o,
    output lines_t          isr_o
);

    lines_t pend_q, isr_q;
    lines_t pend_d, isr_d;

    always_comb begin
        pend_d = pend_q;
        if (take_i) begin
            pend_d[take_idx_i] = 1'b0;
        end
        // A fresh edge wins over the clear of the line being acknowledged.
        pend_d = pend_d | rise_i;
    end

    always_comb begin
        isr_d = isr_q;
        if (eoi_i) begin
            isr_d = isr_d & ~lowest_onehot(isr_q);
        end
        if (take_i) begin
            isr_d[take_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            isr_q  <= '0;
        end else begin
            pend_q <= pend_d;
            isr_q  <= isr_d;
        end
    end

    assign pend_o = pend_q;
    assign isr_o  = isr_q;

    for (genvar g = 0; g < NLINES; g++) begin : g_chk
        assert_rise_latched_R3: assert property (@(posedge clk) disable iff (rst)
            rise_i[g] |=> pend_q[g]);
    end

    assert_take_marks_R6: assert property (@(posedge clk) disable iff (rst)
        take_i |=> isr_q[$past(take_idx_i)]);

    assert_isr_grows_by_one_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(isr_q) <= $countones($past(isr_q)) + 1);

    assert_eoi_retires_one_R8: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !take_i && isr_q != '0) |=> $countones(isr_q) + 1 == $countones($past(isr_q)));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  lines_t pend_i,
    input  lines_t mask_i,
    input  lines_t isr_i,
    output pick_t  pick_o
);

    pick_t  top_isr;
    lines_t eligible;

    always_comb begin
        top_isr  = pick_lowest(isr_i);
        eligible = pend_i & ~mask_i & allowed_lines(top_isr);
        pick_o   = pick_lowest(eligible);
    end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irqc_pkg::*;
#(
    parameter int VEC_BASE     = 8,
    parameter bit CASCADE_EN   = 1'b1,
    parameter int CASCADE_LINE = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_i,
    input  logic       io_wr,
    input  logic       io_addr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       ack_i,
    output logic       int_o,
    output logic [7:0] vec_o,
    input  logic [7:0] slave_vec_i,
    output logic       slave_ack_o
);

    localparam logic [IDXW-1:0] CASC_IDX = IDXW'(CASCADE_LINE);
    localparam byte_t           BASE_V   = byte_t'(VEC_BASE);

    lines_t rise, mask, pend, isr;
    logic   eoi, take;
    pick_t  pick;
    byte_t  own_vec;

    irqc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .req_i  (lines_t'(req_i)),
        .rise_o (rise)
    );

    irqc_io_port u_port (
        .clk      (clk),
        .rst      (rst),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .mask_o   (mask),
        .eoi_o    (eoi)
    );

    irqc_arbiter u_arb (
        .pend_i (pend),
        .mask_i (mask),
        .isr_i  (isr),
        .pick_o (pick)
    );

    irqc_state u_state (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise),
        .take_i     (take),
        .take_idx_i (pick.idx),
        .eoi_i      (eoi),
        .pend_o     (pend),
        .isr_o      (isr)
    );

    assign int_o   = pick.valid;
    assign take    = ack_i && pick.valid;
    assign own_vec = BASE_V + byte_t'(pick.idx);

    if (CASCADE_EN) begin : g_casc
        logic is_casc;
        assign is_casc     = pick.idx == CASC_IDX;
        assign vec_o       = is_casc ? slave_vec_i : own_vec;
        assign slave_ack_o = take && is_casc;
    end else begin : g_nocasc
        logic unused_slave;
        assign unused_slave = ^slave_vec_i;
        assign vec_o        = own_vec;
        assign slave_ack_o  = 1'b0;
    end

    assert_int_needs_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
        int_o |-> (pend & ~mask) != '0);

    assert_stray_ack_R11: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !int_o && !eoi) |=> $stable(isr));

    assert_slave_ack_gated_R9: assert property (@(posedge clk) disable iff (rst)
        slave_ack_o |-> (ack_i && int_o));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !int_o);

endmodule

// File: tb/sim_irq_ctrl_top.sv
`timescale 1ns/1ps
module sim_irq_ctrl_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       io_wr = 1'b0;
    logic       io_addr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       ack_i = 1'b0;
    logic       int_o;
    logic [7:0] vec_o;
    logic [7:0] slave_vec_i = 8'h70;
    logic       slave_ack_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl_top u0 (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .io_wr       (io_wr),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .ack_i       (ack_i),
        .int_o       (int_o),
        .vec_o       (vec_o),
        .slave_vec_i (slave_vec_i),
        .slave_ack_o (slave_ack_o)
    );

    function automatic logic [7:0] expv(int n);
        return (n == 2) ? slave_vec_i : 8'(8 + n);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        step();
        io_wr = 1'b0; io_addr = 1'b1;
    endtask

    task automatic eoi();
        wr(1'b0, 8'h00);
    endtask

    task automatic ack();
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
    endtask

    // One-cycle pulse; returns at the sample point after pending is set.
    task automatic pulse(int n);
        req_i[n] = 1'b1;
        step();
        req_i[n] = 1'b0;
        step();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        io_addr = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 int", 8'(int_o), 8'h0);
        chk("R1 mask", io_rdata, 8'hFF);
        io_addr = 1'b0;
        #1 chk("R2 cmd read", io_rdata, 8'h00);
        io_addr = 1'b1;

        // R2 mask write replaces whole byte
        wr(1'b1, 8'h5A);
        chk("R2 read 5A", io_rdata, 8'h5A);
        wr(1'b1, 8'hC3);
        chk("R2 read C3", io_rdata, 8'hC3);
        wr(1'b1, 8'h00);
        chk("R2 read 00", io_rdata, 8'h00);

        // R3 latency: pending set at the third edge after the rise
        req_i[5] = 1'b1;
        step();
        req_i[5] = 1'b0;
        step();
        chk("R3 early", 8'(int_o), 8'h0);
        step();
        chk("R3 latched", 8'(int_o), 8'h1);
        chk("R3 vec", vec_o, 8'd13);
        ack(); eoi();

        // R3 held level does not re-request
        req_i[6] = 1'b1;
        repeat (3) step();
        chk("R3 level", 8'(int_o), 8'h1);
        ack(); eoi();
        repeat (4) step();
        chk("R3 no retrigger", 8'(int_o), 8'h0);
        req_i[6] = 1'b0;
        repeat (3) step();

        // R5/R6/R9 single-line sweep
        for (int n = 0; n < 8; n++) begin
            pulse(n);
            chk("R5 int", 8'(int_o), 8'h1);
            chk("R5 vec", vec_o, expv(n));
            ack_i = 1'b1;
            #1 chk("R9 slave ack", 8'(slave_ack_o), (n == 2) ? 8'h1 : 8'h0);
            step();
            ack_i = 1'b0;
            chk("R6 int after ack", 8'(int_o), 8'h0);
            eoi();
            chk("R8 idle", 8'(int_o), 8'h0);
        end

        // R4 mask sweep
        for (int n = 0; n < 8; n++) begin
            wr(1'b1, 8'(1 << n));
            pulse(n);
            chk("R4 masked", 8'(int_o), 8'h0);
            wr(1'b1, 8'h00);
            chk("R4 unmasked", 8'(int_o), 8'h1);
            chk("R4 vec", vec_o, expv(n));
            ack(); eoi();
        end

        // R5/R7 simultaneous pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                req_i[i] = 1'b1; req_i[j] = 1'b1;
                step();
                req_i = '0;
                step(); step();
                chk("R5 pair vec", vec_o, expv(i));
                ack();
                chk("R7 lower blocked", 8'(int_o), 8'h0);
                eoi();
                chk("R8 pair next", 8'(int_o), 8'h1);
                chk("R5 pair vec2", vec_o, expv(j));
                ack(); eoi();
            end
        end

        // R7/R8 nesting over all ordered pairs
        for (int j = 0; j < 8; j++) begin
            for (int i = 0; i < 8; i++) begin
                pulse(j);
                ack();
                pulse(i);
                chk("R7 nest int", 8'(int_o), (i < j) ? 8'h1 : 8'h0);
                if (i < j) begin
                    chk("R7 nest vec", vec_o, expv(i));
                    ack();
                    eoi();
                    chk("R8 inner done", 8'(int_o), 8'h0);
                    eoi();
                end else begin
                    eoi();
                    chk("R8 release", 8'(int_o), 8'h1);
                    chk("R8 release vec", vec_o, expv(i));
                    ack(); eoi();
                end
                chk("R8 clean", 8'(int_o), 8'h0);
            end
        end

        // R10 edge detected in the acknowledge cycle of the same line
        pulse(4);
        req_i[4] = 1'b1;
        step();
        req_i[4] = 1'b0;
        step();
        ack();
        chk("R10 blocked by own isr", 8'(int_o), 8'h0);
        eoi();
        chk("R10 still pending", 8'(int_o), 8'h1);
        chk("R10 vec", vec_o, 8'd12);
        ack(); eoi();
        chk("R10 clean", 8'(int_o), 8'h0);

        // R11 stray acknowledge
        ack();
        pulse(7);
        chk("R11 int", 8'(int_o), 8'h1);
        chk("R11 vec", vec_o, 8'd15);
        ack(); eoi();

        // R1 reset clears pending and mask
        pulse(3);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 reset int", 8'(int_o), 8'h0);
        chk("R1 reset mask", io_rdata, 8'hFF);
        wr(1'b1, 8'h00);
        chk("R1 pending gone", 8'(int_o), 8'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule